// File: doc/BRIEF.md
# Stack Relative Address Generator

This unit forms effective addresses for the two stack-relative access forms of a processor with a 24-bit address space and a 16-bit stack pointer. When `start_i` is sampled high, it captures an 8-bit offset, the stack pointer, the Y index and the data bank register. Later changes on those inputs do not affect the access in progress. It reports the result on `ea_o` together with a one-cycle `done_o` strobe and the number of working cycles in `cycles_o`.

In plain mode the stack works as an array that starts at the stack pointer. The address is the stack pointer plus the offset, kept inside bank 0. The stack pointer marks the next free byte, so offset 1 selects the most recently pushed byte. In indirect indexed mode the unit reads a 16-bit pointer from two consecutive bank-0 stack bytes through a byte-wide read port. It places that pointer in the data bank and adds Y, and the sum may carry into the following bank. The unit never writes the stack pointer, and it does not perform the final data access.

Top module: `sr_agu`

## Requirements
- R1: With `mode_i`=0, `ea_o` = {8'h00, (sp_i + opnd_i) mod 2^16}. `data_bank_i` is ignored. `done_o` is high in the second cycle after the `start_i` cycle and `cycles_o` = 1.
- R2: The offset counts upward from the free slot: offset 1 gives sp+1 (the last pushed byte) and offset 0 gives sp itself.
- R3: The stack pointer plus offset sum wraps from 0xFFFF to 0x0000 and stays in bank 0.
- R4: With `mode_i`=1, the low pointer byte is read at {8'h00, sp+opnd} and the high byte at {8'h00, sp+opnd+1}. Both sums are taken mod 2^16, so the high byte of a pointer at 0xFFFF is read at 0x0000.
- R5: In indirect mode, `ea_o` = ({data_bank_i, hi, lo} + {8'h00, y_i}) mod 2^24. A carry out of the low 16 bits increments the bank.
- R6: An indirect access raises `done_o` for one cycle, in the fourth cycle after the `start_i` cycle, with `cycles_o` = 3.
- R7: `mem_req_o` is high for exactly the two pointer fetch cycles of an indirect access, low byte first. A read request is never issued in plain mode. Read data is taken from `mem_rdata_i` in the same cycle as the request.
- R8: `start_i` and changes on the operand inputs while an access is in progress have no effect on that access and start no other one.
- R9: During reset `done_o`, `mem_req_o`, `ea_o` and `cycles_o` are all zero.
- R10: `ea_o` and `cycles_o` hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an address computation |
| mode_i | input | 1 | 0 plain stack relative, 1 indirect indexed by Y |
| opnd_i | input | 8 | Unsigned offset above the stack pointer |
| sp_i | input | 16 | Stack pointer |
| y_i | input | 16 | Y index register |
| data_bank_i | input | 8 | Data bank register |
| mem_req_o | output | 1 | Pointer byte read request |
| mem_addr_o | output | 24 | Pointer byte read address |
| mem_rdata_i | input | 8 | Read data, valid with the request |
| done_o | output | 1 | Result strobe |
| ea_o | output | 24 | Effective address |
| cycles_o | output | 3 | Working cycles of the last access |

## Verification
The bench builds the unit with its default widths: an 8-bit offset, 16-bit stack pointer and index, and an 8-bit bank. With these widths, stimulus of a few vectors can reach the 16-bit wrap of the stack sum, both for a plain access and for a pointer whose high byte lies past 0xFFFF. The same widths put a Y carry across a bank boundary and a carry out of the top bank within reach. The memory model answers only at the two addresses the requirements predict, so a wrong fetch address shows up as a wrong result.

// File: rtl/sr_agu_pkg.sv
package sr_agu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_LO,
    ST_HI,
    ST_IDX
  } agu_state_e;

  typedef enum logic {
    MODE_STK = 1'b0,
    MODE_IND = 1'b1
  } agu_mode_e;

endpackage

// File: rtl/sr_stack_add.sv
module sr_stack_add #(
  parameter int OP_W  = 8,
  parameter int REG_W = 16
) (
  input  logic [REG_W-1:0] sp_i,
  input  logic [OP_W-1:0]  opnd_i,
  input  logic             hi_sel_i,
  output logic [REG_W-1:0] sum_o
);
  localparam int PAD_W = REG_W - OP_W;

  // carry out of REG_W is dropped: wrap inside bank 0
  always_comb begin
    sum_o = sp_i + {{PAD_W{1'b0}}, opnd_i} + {{(REG_W-1){1'b0}}, hi_sel_i};
  end
endmodule

// File: rtl/sr_index_add.sv
module sr_index_add #(
  parameter int REG_W  = 16,
  parameter int BANK_W = 8
) (
  input  logic [BANK_W-1:0]       bank_i,
  input  logic [REG_W-1:0]        ptr_i,
  input  logic [REG_W-1:0]        y_i,
  output logic [REG_W+BANK_W-1:0] ea_o
);
  localparam int ADDR_W = REG_W + BANK_W;

  logic [ADDR_W-1:0] base;
  assign base = {bank_i, ptr_i};

  // carry out of the pointer field advances the bank
  always_comb begin
    ea_o = base + {{BANK_W{1'b0}}, y_i};
  end
endmodule

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import sr_agu_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int REG_W  = 16,
  parameter int BANK_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    mode_i,
  input  logic [OP_W-1:0]         opnd_i,
  input  logic [REG_W-1:0]        sp_i,
  input  logic [REG_W-1:0]        y_i,
  input  logic [BANK_W-1:0]       bank_i,
  input  logic [REG_W/2-1:0]      mem_rdata_i,
  input  logic [REG_W-1:0]        stk_sum_i,
  input  logic [REG_W+BANK_W-1:0] idx_ea_i,
  output logic [OP_W-1:0]         op_o,
  output logic [REG_W-1:0]        sp_o,
  output logic                    hi_sel_o,
  output logic [BANK_W-1:0]       bank_o,
  output logic [REG_W-1:0]        ptr_o,
  output logic [REG_W-1:0]        y_o,
  output logic                    mem_req_o,
  output logic                    done_o,
  output logic [REG_W+BANK_W-1:0] ea_o,
  output logic [CNT_W-1:0]        cycles_o
);
  localparam int ADDR_W = REG_W + BANK_W;
  localparam int BYTE_W = REG_W / 2;

  agu_state_e        state_q;
  logic [OP_W-1:0]   op_q;
  logic [REG_W-1:0]  sp_q;
  logic [REG_W-1:0]  y_q;
  logic [BANK_W-1:0] bank_q;
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic [ADDR_W-1:0] ea_q;
  logic [CNT_W-1:0]  cyc_q;

  assign op_o      = op_q;
  assign sp_o      = sp_q;
  assign y_o       = y_q;
  assign bank_o    = bank_q;
  assign ptr_o     = {hi_q, lo_q};
  assign hi_sel_o  = (state_q == ST_HI);
  assign mem_req_o = (state_q == ST_LO) || (state_q == ST_HI);
  assign done_o    = done_q;
  assign ea_o      = ea_q;
  assign cycles_o  = cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      sp_q    <= '0;
      y_q     <= '0;
      bank_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      ea_q    <= '0;
      cyc_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q != ST_IDLE) cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            op_q    <= opnd_i;
            sp_q    <= sp_i;
            y_q     <= y_i;
            bank_q  <= bank_i;
            cnt_q   <= '0;
            state_q <= (agu_mode_e'(mode_i) == MODE_IND) ? ST_LO : ST_CALC;
          end
        end
        ST_CALC: begin
          ea_q    <= {{BANK_W{1'b0}}, stk_sum_i};
          cyc_q   <= cnt_q + 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_LO: begin
          lo_q    <= mem_rdata_i;
          state_q <= ST_HI;
        end
        ST_HI: begin
          hi_q    <= mem_rdata_i;
          state_q <= ST_IDX;
        end
        ST_IDX: begin
          ea_q    <= idx_ea_i;
          cyc_q   <= cnt_q + 1'b1;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_cycles_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cycles_o == CNT_W'(1) || cycles_o == CNT_W'(3)));

  p_plain_bank0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cycles_o == CNT_W'(1)) |-> (ea_o[ADDR_W-1:REG_W] == '0));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(ea_o) && $stable(cycles_o)));

endmodule

// File: rtl/sr_agu.sv
module sr_agu #(
  parameter int OP_W   = 8,
  parameter int REG_W  = 16,
  parameter int BANK_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    mode_i,
  input  logic [OP_W-1:0]         opnd_i,
  input  logic [REG_W-1:0]        sp_i,
  input  logic [REG_W-1:0]        y_i,
  input  logic [BANK_W-1:0]       data_bank_i,
  output logic                    mem_req_o,
  output logic [REG_W+BANK_W-1:0] mem_addr_o,
  input  logic [REG_W/2-1:0]      mem_rdata_i,
  output logic                    done_o,
  output logic [REG_W+BANK_W-1:0] ea_o,
  output logic [CNT_W-1:0]        cycles_o
);
  localparam int ADDR_W = REG_W + BANK_W;

  logic [OP_W-1:0]   op_l;
  logic [REG_W-1:0]  sp_l;
  logic [REG_W-1:0]  y_l;
  logic [BANK_W-1:0] bank_l;
  logic [REG_W-1:0]  ptr;
  logic              hi_sel;
  logic [REG_W-1:0]  stk_sum;
  logic [ADDR_W-1:0] idx_ea;

  sr_stack_add #(.OP_W(OP_W), .REG_W(REG_W)) u_stack_add (
    .sp_i     (sp_l),
    .opnd_i   (op_l),
    .hi_sel_i (hi_sel),
    .sum_o    (stk_sum)
  );

  sr_index_add #(.REG_W(REG_W), .BANK_W(BANK_W)) u_index_add (
    .bank_i (bank_l),
    .ptr_i  (ptr),
    .y_i    (y_l),
    .ea_o   (idx_ea)
  );

  sr_ctrl #(.OP_W(OP_W), .REG_W(REG_W), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .opnd_i      (opnd_i),
    .sp_i        (sp_i),
    .y_i         (y_i),
    .bank_i      (data_bank_i),
    .mem_rdata_i (mem_rdata_i),
    .stk_sum_i   (stk_sum),
    .idx_ea_i    (idx_ea),
    .op_o        (op_l),
    .sp_o        (sp_l),
    .hi_sel_o    (hi_sel),
    .bank_o      (bank_l),
    .ptr_o       (ptr),
    .y_o         (y_l),
    .mem_req_o   (mem_req_o),
    .done_o      (done_o),
    .ea_o        (ea_o),
    .cycles_o    (cycles_o)
  );

  // pointer fetches always target bank 0
  assign mem_addr_o = {{BANK_W{1'b0}}, stk_sum};

  p_fetch_bank0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[ADDR_W-1:REG_W] == '0));

  p_hi_after_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |=> (mem_req_o &&
      mem_addr_o[REG_W-1:0] == $past(mem_addr_o[REG_W-1:0]) + 1'b1));

  p_two_fetches_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |=> !mem_req_o);

  p_no_req_at_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

endmodule

// File: tb/sr_agu_tb.sv
module sr_agu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 89;
  localparam int NV = 8;

  // {mode, opnd, sp, y, bank, ptr_lo, ptr_hi, expected ea}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 8'h01, 16'h01F0, 16'h0000, 8'h5A, 8'h00, 8'h00, 24'h0001F1},
    {1'b0, 8'h00, 16'h01F0, 16'h0000, 8'h5A, 8'h00, 8'h00, 24'h0001F0},
    {1'b0, 8'hFF, 16'h1234, 16'h4444, 8'h5A, 8'h00, 8'h00, 24'h001333},
    {1'b0, 8'h20, 16'hFFF0, 16'h0000, 8'hC3, 8'h00, 8'h00, 24'h000010},
    {1'b1, 8'h03, 16'h0100, 16'h0002, 8'h12, 8'h34, 8'h56, 24'h125636},
    {1'b1, 8'h01, 16'h01FD, 16'h0020, 8'h7E, 8'hF0, 8'hFF, 24'h7F0010},
    {1'b1, 8'hFF, 16'hFF00, 16'h0000, 8'h00, 8'h00, 8'h80, 24'h008000},
    {1'b1, 8'h10, 16'h2000, 16'hFFFF, 8'hFF, 8'hFF, 8'hFF, 24'h00FFFE}
  };
  localparam string VREQ [NV] = '{"R2", "R2", "R1", "R3", "R5", "R5", "R4", "R5"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [7:0]  opnd = '0;
  logic [15:0] sp = '0;
  logic [15:0] y = '0;
  logic [7:0]  bank = '0;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        done;
  logic [23:0] ea;
  logic [2:0]  cycles;

  logic [23:0] lo_a = '0, hi_a = '0;
  logic [7:0]  lo_v = '0, hi_v = '0;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model answers only at the predicted pointer addresses
  assign mem_rdata = (mem_addr == lo_a) ? lo_v : (mem_addr == hi_a) ? hi_v : 8'hEE;

  sr_agu u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .mode_i      (mode),
    .opnd_i      (opnd),
    .sp_i        (sp),
    .y_i         (y),
    .data_bank_i (bank),
    .mem_req_o   (mem_req),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .done_o      (done),
    .ea_o        (ea),
    .cycles_o    (cycles)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // runs one access; a pulse of start during the run is injected when disturb is set
  task automatic run_case(input logic [VW-1:0] v, input string req, input bit disturb);
    logic        m;
    logic [23:0] exp_ea;
    int lat = 0;
    int nreq = 0;
    m      = v[88];
    exp_ea = v[23:0];
    @(negedge clk);
    mode  = m;
    opnd  = v[87:80];
    sp    = v[79:64];
    y     = v[63:48];
    bank  = v[47:40];
    lo_v  = v[39:32];
    hi_v  = v[31:24];
    lo_a  = {8'h00, v[79:64] + {8'h00, v[87:80]}};
    hi_a  = {8'h00, v[79:64] + {8'h00, v[87:80]} + 16'h0001};
    start = 1'b1;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (disturb && lat == 1) begin
        start = 1'b1;
        mode  = 1'b0;
        opnd  = 8'h77;
        sp    = 16'hABCD;
        y     = 16'h1111;
        bank  = 8'h99;
      end
      if (mem_req) begin
        if (nreq == 0) check(mem_addr == lo_a, "R4", "low byte address", {8'h0, mem_addr}, {8'h0, lo_a});
        else           check(mem_addr == hi_a, "R4", "high byte address", {8'h0, mem_addr}, {8'h0, hi_a});
        nreq++;
      end
    end while (!done && lat < 20);
    start = 1'b0;
    check(ea == exp_ea, req, "effective address", {8'h0, ea}, {8'h0, exp_ea});
    check(cycles == (m ? 3'd3 : 3'd1), m ? "R6" : "R1", "cycle count",
          {29'h0, cycles}, m ? 32'd3 : 32'd1);
    check(lat == (m ? 4 : 2), m ? "R6" : "R1", "done latency", 32'(lat), m ? 32'd4 : 32'd2);
    check(nreq == (m ? 2 : 0), "R7", "request count", 32'(nreq), m ? 32'd2 : 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && mem_req == 1'b0, "R9", "strobes in reset", {30'h0, done, mem_req}, 32'h0);
    check(ea == '0 && cycles == '0, "R9", "outputs in reset", {5'h0, cycles, ea}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_case(VEC[i], VREQ[i], 1'b0);

    // R8: start and input changes during an indirect access
    run_case(VEC[4], "R8", 1'b1);
    held = ea;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(done == 1'b0, "R8", "no extra completion", {31'h0, done}, 32'h0);
      check(ea == held, "R10", "result held", {8'h0, ea}, {8'h0, held});
    end
    check(cycles == 3'd3, "R10", "count held", {29'h0, cycles}, 32'd3);

    // R3 again after an indirect access: plain wrap at the top of bank 0
    run_case({1'b0, 8'hFF, 16'hFF01, 16'h0000, 8'h01, 8'h00, 8'h00, 24'h000000}, "R3", 1'b0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule